// File: doc/BRIEF.md
# Four-Wide Register Rename Stage

This block renames a group of up to four decoded instructions in a single clock cycle. Each lane carries one destination and two source specifiers that name architectural registers. The block maps sources to physical tags, gives every writing lane a fresh physical tag from a circular free list, and reports the physical tag that each destination held before, so that later logic can release it. All of the group's outputs appear combinationally in the cycle the group is presented. The map table and the free list update at the clock edge that accepts the group.

Dependences inside the group are resolved by a priority bypass. A source that an earlier lane of the same group writes takes the new tag of the nearest such earlier lane. Only sources with no earlier writer in the group read the map table. When the free list holds fewer tags than the group needs, the whole group is refused and no state changes. A single return port pushes freed tags back onto the tail of the free list. Architectural register 0 is never renamed.

Top module: `rn_stage`

## Requirements
- R1: Each lane with lane valid, write enable and a nonzero destination takes a distinct new tag. Tags are handed out in lane order (lane 0 first) from the head of the free list, and an accepted group removes exactly that many tags.
- R2: A source that no earlier lane of the group writes gets the map table entry for that register.
- R3: A source that an earlier lane of the group writes gets that lane's new tag, not the table entry.
- R4: When several earlier lanes write the same register, a reader takes the tag of the highest-numbered earlier writer.
- R5: The old-tag output of a writing lane is the mapping its destination held just before it. This is the nearest earlier writer's new tag if one exists, and otherwise the table entry.
- R6: After an accepted group, the table holds, for each register written, the new tag of the last lane that wrote it.
- R7: Register 0 always resolves to physical tag 0. A destination of 0 allocates nothing, and its new and old tags read 0.
- R8: If the free-list count is below the number of tags the group needs, `grp_fire` stays low, the free list is unchanged and the table is unchanged.
- R9: A tag on the return port is written at the tail of the free list. Returned tags are handed out again in the order they were returned.
- R10: After reset, register i maps to tag i, and the free list holds tags 32 to 63 with tag 32 at the head.
- R11: While `grp_valid` is low, or for a lane whose `ln_vld` is low, all of that lane's tag outputs are 0 and it changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_valid | input | 1 | A group is presented this cycle |
| ln_vld | input | 4 | Per-lane instruction valid |
| ln_wr | input | 4 | Per-lane destination write enable |
| ln_dst | input | 4x5 | Per-lane destination register |
| ln_sa | input | 4x5 | Per-lane first source register |
| ln_sb | input | 4x5 | Per-lane second source register |
| ret_vld | input | 1 | Return a freed tag this cycle |
| ret_tag | input | 6 | Tag being returned |
| grp_fire | output | 1 | Group accepted and committed at this edge |
| tag_sa | output | 4x6 | Physical tag for first source |
| tag_sb | output | 4x6 | Physical tag for second source |
| tag_new | output | 4x6 | Newly allocated destination tag |
| tag_old | output | 4x6 | Previous mapping of destination |

## Verification
One group renames the same register twice and then reads it. A design that bypassed from the oldest writer, or that read the table, would hand the reader a stale tag. It would also report the wrong old tag for the second writer. Groups that mix lanes with no write, a write to register 0 and invalid lanes catch designs that waste a tag, allocate to register 0 or leak outputs from idle lanes. The free list is drained to exactly zero, and then tags are returned one at a time. A design that accepted a group it could not fully serve, or that handed out tags in the wrong order after a return, would show wrong new tags or a stale mapping when the table is read back.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int LANES  = 4;
  localparam int ARCH_N = 32;
  localparam int PHYS_N = 64;
  localparam int AW     = $clog2(ARCH_N);
  localparam int PW     = $clog2(PHYS_N);
  localparam int CW     = PW + 1;
  localparam int NW     = $clog2(LANES + 1);
  localparam int NR     = 3 * LANES;
endpackage

// File: rtl/rn_freelist.sv
module rn_freelist #(
  parameter int PW        = 6,
  parameter int LANES     = 4,
  parameter int NW        = 3,
  parameter int INIT_CNT  = 32,
  parameter int INIT_BASE = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pop_en,
  input  logic [NW-1:0]              pop_num,
  input  logic                       push_en,
  input  logic [PW-1:0]              push_tag,
  output logic [LANES-1:0][PW-1:0]   peek,
  output logic [PW:0]                cnt
);
  localparam int DEPTH = 1 << PW;
  localparam int CW    = PW + 1;

  logic [PW-1:0] mem_q [DEPTH];
  logic [PW-1:0] head_q, head_d, tail_q, tail_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    for (int i = 0; i < LANES; i++) peek[i] = mem_q[head_q + PW'(i)];
  end

  always_comb begin
    head_d = pop_en  ? head_q + PW'(pop_num) : head_q;
    tail_d = push_en ? tail_q + PW'(1)       : tail_q;
    cnt_d  = cnt_q - (pop_en ? CW'(pop_num) : '0) + (push_en ? CW'(1) : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        mem_q[i] <= (i < INIT_CNT) ? PW'(INIT_BASE + i) : '0;
      head_q <= '0;
      tail_q <= PW'(INIT_CNT);
      cnt_q  <= CW'(INIT_CNT);
    end else begin
      if (push_en) mem_q[tail_q] <= push_tag;
      if (pop_en || push_en) begin
        head_q <= head_d;
        tail_q <= tail_d;
        cnt_q  <= cnt_d;
      end
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/rn_maptable.sv
module rn_maptable #(
  parameter int ARCH_N = 32,
  parameter int AW     = 5,
  parameter int PW     = 6,
  parameter int LANES  = 4,
  parameter int NR     = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NR-1:0][AW-1:0]    rd_addr,
  output logic [NR-1:0][PW-1:0]    rd_data,
  input  logic [LANES-1:0]         wr_en,
  input  logic [LANES-1:0][AW-1:0] wr_addr,
  input  logic [LANES-1:0][PW-1:0] wr_data
);
  logic [PW-1:0] map_q [ARCH_N];
  logic [PW-1:0] map_d [ARCH_N];

  always_comb begin
    for (int r = 0; r < NR; r++) rd_data[r] = map_q[rd_addr[r]];
  end

  // later lanes override earlier ones: last writer wins
  always_comb begin
    for (int i = 0; i < ARCH_N; i++) map_d[i] = map_q[i];
    for (int k = 0; k < LANES; k++)
      if (wr_en[k]) map_d[wr_addr[k]] = wr_data[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ARCH_N; i++) map_q[i] <= PW'(i);
    end else if (|wr_en) begin
      for (int i = 0; i < ARCH_N; i++) map_q[i] <= map_d[i];
    end
  end
endmodule

// File: rtl/rn_bypass.sv
module rn_bypass #(
  parameter int LANES = 4,
  parameter int AW    = 5,
  parameter int PW    = 6
) (
  input  logic [LANES-1:0]         alloc,
  input  logic [LANES-1:0][AW-1:0] ln_dst,
  input  logic [LANES-1:0][AW-1:0] ln_sa,
  input  logic [LANES-1:0][AW-1:0] ln_sb,
  input  logic [LANES-1:0][PW-1:0] map_sa,
  input  logic [LANES-1:0][PW-1:0] map_sb,
  input  logic [LANES-1:0][PW-1:0] map_od,
  input  logic [LANES-1:0][PW-1:0] new_tag,
  output logic [LANES-1:0][PW-1:0] rs_a,
  output logic [LANES-1:0][PW-1:0] rs_b,
  output logic [LANES-1:0][PW-1:0] rs_o
);
  // the last lane is never an earlier writer for anyone
  logic unused_last;
  assign unused_last = ^{alloc[LANES-1], ln_dst[LANES-1], new_tag[LANES-1]};

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_comb begin
      rs_a[k] = map_sa[k];
      rs_b[k] = map_sb[k];
      rs_o[k] = map_od[k];
      // ascending scan: the nearest earlier writer is applied last
      for (int j = 0; j < k; j++) begin
        if (alloc[j]) begin
          if (ln_dst[j] == ln_sa[k])  rs_a[k] = new_tag[j];
          if (ln_dst[j] == ln_sb[k])  rs_b[k] = new_tag[j];
          if (ln_dst[j] == ln_dst[k]) rs_o[k] = new_tag[j];
        end
      end
      if (ln_sa[k] == '0)  rs_a[k] = '0;
      if (ln_sb[k] == '0)  rs_b[k] = '0;
      if (ln_dst[k] == '0) rs_o[k] = '0;
    end
  end
endmodule

// File: rtl/rn_stage.sv
module rn_stage
  import rn_pkg::*;
#(
  parameter int P_LANES  = LANES,
  parameter int P_AW     = AW,
  parameter int P_PW     = PW
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          grp_valid,
  input  logic [P_LANES-1:0]            ln_vld,
  input  logic [P_LANES-1:0]            ln_wr,
  input  logic [P_LANES-1:0][P_AW-1:0]  ln_dst,
  input  logic [P_LANES-1:0][P_AW-1:0]  ln_sa,
  input  logic [P_LANES-1:0][P_AW-1:0]  ln_sb,
  input  logic                          ret_vld,
  input  logic [P_PW-1:0]               ret_tag,
  output logic                          grp_fire,
  output logic [P_LANES-1:0][P_PW-1:0]  tag_sa,
  output logic [P_LANES-1:0][P_PW-1:0]  tag_sb,
  output logic [P_LANES-1:0][P_PW-1:0]  tag_new,
  output logic [P_LANES-1:0][P_PW-1:0]  tag_old
);
  localparam int L_NW = $clog2(P_LANES + 1);
  localparam int L_LW = (P_LANES > 1) ? $clog2(P_LANES) : 1;
  localparam int L_CW = P_PW + 1;
  localparam int L_NR = 3 * P_LANES;
  localparam int L_AN = 1 << P_AW;

  logic [P_LANES-1:0]           eff, alloc, wr_en;
  logic [L_NW-1:0]              need;
  logic [L_CW-1:0]              free_cnt;
  logic [P_LANES-1:0][P_PW-1:0] peek, new_raw, rs_a, rs_b, rs_o;
  logic [L_NR-1:0][P_AW-1:0]    rd_addr;
  logic [L_NR-1:0][P_PW-1:0]    rd_data;
  logic [P_LANES-1:0][P_PW-1:0] map_sa, map_sb, map_od;

  always_comb begin
    for (int k = 0; k < P_LANES; k++) begin
      eff[k]   = grp_valid & ln_vld[k];
      alloc[k] = eff[k] & ln_wr[k] & (ln_dst[k] != '0);
    end
    need     = L_NW'($countones(alloc));
    grp_fire = grp_valid & (free_cnt >= L_CW'(need));
    wr_en    = alloc & {P_LANES{grp_fire}};
  end

  // lane-ordered allocation from the head of the free list
  always_comb begin
    logic [L_NW-1:0] slot;
    slot = '0;
    for (int k = 0; k < P_LANES; k++) begin
      new_raw[k] = '0;
      if (alloc[k]) begin
        new_raw[k] = peek[slot[L_LW-1:0]];
        slot       = slot + L_NW'(1);
      end
    end
  end

  always_comb begin
    for (int k = 0; k < P_LANES; k++) begin
      rd_addr[k]             = ln_sa[k];
      rd_addr[P_LANES + k]   = ln_sb[k];
      rd_addr[2*P_LANES + k] = ln_dst[k];
      map_sa[k] = rd_data[k];
      map_sb[k] = rd_data[P_LANES + k];
      map_od[k] = rd_data[2*P_LANES + k];
    end
  end

  rn_freelist #(
    .PW(P_PW), .LANES(P_LANES), .NW(L_NW),
    .INIT_CNT((1 << P_PW) - L_AN), .INIT_BASE(L_AN)
  ) u_free (
    .clk(clk), .rst_n(rst_n),
    .pop_en(grp_fire), .pop_num(need),
    .push_en(ret_vld), .push_tag(ret_tag),
    .peek(peek), .cnt(free_cnt)
  );

  rn_maptable #(
    .ARCH_N(L_AN), .AW(P_AW), .PW(P_PW), .LANES(P_LANES), .NR(L_NR)
  ) u_map (
    .clk(clk), .rst_n(rst_n),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(ln_dst), .wr_data(new_raw)
  );

  rn_bypass #(.LANES(P_LANES), .AW(P_AW), .PW(P_PW)) u_byp (
    .alloc(alloc), .ln_dst(ln_dst), .ln_sa(ln_sa), .ln_sb(ln_sb),
    .map_sa(map_sa), .map_sb(map_sb), .map_od(map_od), .new_tag(new_raw),
    .rs_a(rs_a), .rs_b(rs_b), .rs_o(rs_o)
  );

  always_comb begin
    for (int k = 0; k < P_LANES; k++) begin
      tag_sa[k]  = eff[k]   ? rs_a[k] : '0;
      tag_sb[k]  = eff[k]   ? rs_b[k] : '0;
      tag_old[k] = alloc[k] ? rs_o[k] : '0;
      tag_new[k] = new_raw[k];
    end
  end
endmodule

// File: rtl/rn_stage_chk.sv
module rn_stage_chk
  import rn_pkg::*;
(
  input logic                       clk,
  input logic                       rst_n,
  input logic                       grp_valid,
  input logic                       grp_fire,
  input logic                       ret_vld,
  input logic [LANES-1:0]           ln_vld,
  input logic [LANES-1:0]           ln_wr,
  input logic [LANES-1:0][AW-1:0]   ln_dst,
  input logic [LANES-1:0][AW-1:0]   ln_sa,
  input logic [LANES-1:0][PW-1:0]   tag_sa,
  input logic [LANES-1:0][PW-1:0]   tag_new,
  input logic [CW-1:0]              free_cnt
);
  logic [CW-1:0] need_c;
  logic          distinct, zero_ok, idle_zero;

  always_comb begin
    logic [LANES-1:0] wmask;
    for (int k = 0; k < LANES; k++)
      wmask[k] = grp_valid & ln_vld[k] & ln_wr[k] & (ln_dst[k] != '0);
    need_c   = CW'($countones(wmask));
    distinct = 1'b1;
    zero_ok  = 1'b1;
    for (int a = 0; a < LANES; a++) begin
      if (ln_dst[a] == '0 && tag_new[a] != '0) zero_ok = 1'b0;
      if (ln_sa[a] == '0 && tag_sa[a] != '0)   zero_ok = 1'b0;
      for (int b = a + 1; b < LANES; b++)
        if (tag_new[a] != '0 && tag_new[a] == tag_new[b]) distinct = 1'b0;
    end
    idle_zero = (tag_new == '0) && (tag_sa == '0);
  end

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_valid && !grp_fire && !ret_vld) |=> (free_cnt == $past(free_cnt)));

  p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_fire && !ret_vld) |=> (free_cnt == $past(free_cnt) - $past(need_c)));

  p_distinct_r1: assert property (@(posedge clk) disable iff (!rst_n)
    grp_fire |-> distinct);

  p_reg_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    zero_ok);

  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= CW'(PHYS_N));

  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_valid |-> (idle_zero && !grp_fire));
endmodule

bind rn_stage rn_stage_chk u_chk (
  .clk(clk), .rst_n(rst_n), .grp_valid(grp_valid), .grp_fire(grp_fire),
  .ret_vld(ret_vld), .ln_vld(ln_vld), .ln_wr(ln_wr), .ln_dst(ln_dst),
  .ln_sa(ln_sa), .tag_sa(tag_sa), .tag_new(tag_new), .free_cnt(free_cnt)
);

// File: tb/sim_rn_stage.sv
`timescale 1ns/1ps
module sim_rn_stage;
  logic clk, rst_n, grp_valid, ret_vld, grp_fire;
  logic [3:0] ln_vld, ln_wr;
  logic [3:0][4:0] ln_dst, ln_sa, ln_sb;
  logic [5:0] ret_tag;
  logic [3:0][5:0] tag_sa, tag_sb, tag_new, tag_old;
  int checks = 0, failures = 0;
  bit done = 0;

  rn_stage u0 (.*);

  initial clk = 0;
  always #4 clk = ~clk;

  // lane entry: {vld, wr, dst, sa, sb, exp_sa, exp_sb, exp_new, exp_old}
  localparam logic [40:0] LANE_TAB [16] = '{
    {1'b1,1'b1,5'd1,5'd2,5'd3, 6'd2, 6'd3, 6'd32,6'd1},
    {1'b1,1'b1,5'd4,5'd1,5'd2, 6'd32,6'd2, 6'd33,6'd4},
    {1'b1,1'b1,5'd1,5'd4,5'd0, 6'd33,6'd0, 6'd34,6'd32},
    {1'b1,1'b1,5'd5,5'd1,5'd2, 6'd34,6'd2, 6'd35,6'd5},
    {1'b1,1'b1,5'd6,5'd1,5'd5, 6'd34,6'd35,6'd36,6'd6},
    {1'b1,1'b0,5'd9,5'd4,5'd6, 6'd33,6'd36,6'd0, 6'd0},
    {1'b1,1'b1,5'd0,5'd1,5'd7, 6'd34,6'd7, 6'd0, 6'd0},
    {1'b1,1'b1,5'd6,5'd6,5'd4, 6'd36,6'd33,6'd37,6'd36},
    {1'b1,1'b1,5'd6,5'd1,5'd1, 6'd0, 6'd0, 6'd0, 6'd0},
    {1'b1,1'b1,5'd1,5'd1,5'd1, 6'd0, 6'd0, 6'd0, 6'd0},
    {1'b1,1'b1,5'd4,5'd1,5'd1, 6'd0, 6'd0, 6'd0, 6'd0},
    {1'b1,1'b1,5'd5,5'd1,5'd1, 6'd0, 6'd0, 6'd0, 6'd0},
    {1'b1,1'b1,5'd2,5'd6,5'd1, 6'd37,6'd34,6'd38,6'd2},
    {1'b0,1'b1,5'd3,5'd3,5'd3, 6'd0, 6'd0, 6'd0, 6'd0},
    {1'b1,1'b0,5'd0,5'd31,5'd0,6'd31,6'd0, 6'd0, 6'd0},
    {1'b1,1'b1,5'd31,5'd2,5'd31,6'd38,6'd31,6'd39,6'd31}
  };
  // group entry: {grp_valid, exp_fire}
  localparam logic [1:0] GRP_TAB [4] = '{2'b11, 2'b11, 2'b00, 2'b11};

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    grp_valid = 0; ret_vld = 0; ret_tag = 0;
    ln_vld = 0; ln_wr = 0; ln_dst = '0; ln_sa = '0; ln_sb = '0;
  endtask

  task automatic lane(int k, bit v, bit w, int d, int a, int b);
    ln_vld[k] = v; ln_wr[k] = w;
    ln_dst[k] = 5'(d); ln_sa[k] = 5'(a); ln_sb[k] = 5'(b);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    // R10: reset mapping and free-list head, seen during reset
    @(negedge clk);
    grp_valid = 1;
    lane(0, 1, 0, 0, 31, 5);
    lane(1, 1, 1, 3, 0, 17);
    #2;
    chk("R10 map r31", tag_sa[0], 31);
    chk("R10 map r5", tag_sb[0], 5);
    chk("R10 map r17", tag_sb[1], 17);
    chk("R10 first free tag", tag_new[1], 32);
    chk("R10 old r3", tag_old[1], 3);
    @(negedge clk);
    idle();
    rst_n = 1;

    // table-driven groups
    for (int v = 0; v < 4; v++) begin
      @(negedge clk);
      grp_valid = GRP_TAB[v][1];
      for (int k = 0; k < 4; k++) begin
        logic [40:0] e;
        e = LANE_TAB[v*4+k];
        lane(k, e[40], e[39], int'(e[38:34]), int'(e[33:29]), int'(e[28:24]));
      end
      #2;
      chk("R8/R11 fire", grp_fire, GRP_TAB[v][0]);
      for (int k = 0; k < 4; k++) begin
        logic [40:0] e;
        e = LANE_TAB[v*4+k];
        chk("R2/R3/R4/R11 src a", tag_sa[k], int'(e[23:18]));
        chk("R2/R3/R7 src b", tag_sb[k], int'(e[17:12]));
        chk("R1/R7 new tag", tag_new[k], int'(e[11:6]));
        chk("R5/R7 old tag", tag_old[k], int'(e[5:0]));
      end
    end

    // R6: last writer of each register is in the table
    @(negedge clk);
    idle(); grp_valid = 1;
    lane(0, 1, 0, 0, 1, 4);
    lane(1, 1, 0, 0, 5, 6);
    lane(2, 1, 1, 0, 0, 0);
    #2;
    chk("R6 r1 last writer", tag_sa[0], 34);
    chk("R6 r4", tag_sb[0], 33);
    chk("R6 r5", tag_sa[1], 35);
    chk("R6 r6 last writer", tag_sb[1], 37);
    chk("R7 dst r0 no tag", tag_new[2], 0);
    chk("R7 zero-need fire", grp_fire, 1);

    // drain the free list: 24 tags remain
    for (int g = 0; g < 6; g++) begin
      @(negedge clk);
      idle(); grp_valid = 1;
      for (int k = 0; k < 4; k++) lane(k, 1, 1, 8 + k, 0, 0);
      #2;
      chk("R1 drain fire", grp_fire, 1);
      for (int k = 0; k < 4; k++) chk("R1 drain new", tag_new[k], 40 + 4*g + k);
    end

    // R8: group needing 2 with 0 free
    @(negedge clk);
    idle(); grp_valid = 1;
    lane(0, 1, 1, 12, 8, 0);
    lane(1, 1, 1, 13, 12, 9);
    #2;
    chk("R8 stall empty", grp_fire, 0);
    @(negedge clk);
    idle(); grp_valid = 1;
    lane(0, 1, 0, 0, 12, 13);
    #2;
    chk("R8 map r12 untouched", tag_sa[0], 12);
    chk("R8 map r13 untouched", tag_sb[0], 13);

    // R9: return tags one per cycle
    @(negedge clk);
    idle(); ret_vld = 1; ret_tag = 6'd1;
    @(negedge clk);
    idle(); grp_valid = 1;
    lane(0, 1, 1, 12, 8, 0);
    lane(1, 1, 1, 13, 12, 9);
    #2;
    chk("R8 stall one short", grp_fire, 0);
    @(negedge clk);
    idle(); ret_vld = 1; ret_tag = 6'd32;
    @(negedge clk);
    idle(); grp_valid = 1;
    lane(0, 1, 1, 12, 8, 0);
    lane(1, 1, 1, 13, 12, 9);
    #2;
    chk("R9 fire after return", grp_fire, 1);
    chk("R9 first returned tag", tag_new[0], 1);
    chk("R9 second returned tag", tag_new[1], 32);
    chk("R3 bypass r12", tag_sa[1], 1);
    chk("R2 map r9", tag_sb[1], 61);
    chk("R2 map r8", tag_sa[0], 60);
    chk("R5 old r12", tag_old[0], 12);
    chk("R5 old r13", tag_old[1], 13);
    @(negedge clk);
    idle(); grp_valid = 1;
    lane(3, 1, 0, 0, 12, 13);
    #2;
    chk("R6 r12 after retry", tag_sa[3], 1);
    chk("R6 r13 after retry", tag_sb[3], 32);
    chk("R11 idle lane zero", tag_sa[0], 0);

    @(negedge clk);
    idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule